// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers the event pulses that the command and data engines of an SD/MMC host controller raise, keeps them as sticky flags, and turns them into a single interrupt line. Each event pulse lasts one cycle. There are eleven events: command complete, transfer complete, command timeout, command CRC error, command end-bit error, command index error, data timeout, data CRC error, data end-bit error, buffer read ready and buffer write ready.

Software reaches three registers through a simple 32-bit register port. The capture mask decides whether an event is latched at all. The flag register holds the latched events and is cleared by writing ones. The line mask decides which latched flags drive the interrupt line. Because the two masks are separate, software can poll flags while the interrupt line stays silent.

The block also offers four combinational verdicts taken from the flags. They tell whether a command has finished, whether it failed, whether a data transfer has finished (which also waits for the DMA-done input when DMA is in use), and whether the data phase failed.

Top module: `sdh_irq_unit`

## Requirements
- R1: Synchronous active-low reset clears the flag register, the capture mask and the line mask to zero, and drives irq_o low.
- R2: An event pulse on evt_i bit k sets flag bit k at the next clock edge when capture-mask bit k is set. The bit positions are: 0 command complete, 1 transfer complete, 2 command timeout, 3 command CRC error, 4 command end-bit error, 5 command index error, 6 data timeout, 7 data CRC error, 8 data end-bit error, 9 buffer read ready, 10 buffer write ready.
- R3: An event whose capture-mask bit is clear never sets its flag bit.
- R4: A write to the flag register clears each flag whose write-data bit is one and leaves the other flags alone. Writing all ones clears every flag.
- R5: If an accepted event and a clearing write hit the same flag bit in the same cycle, the flag stays set.
- R6: irq_o is the OR of (flags AND line mask), registered: it changes one clock edge after the flags or the line mask change.
- R7: With the line mask all zero, irq_o stays low while flags still latch and read back.
- R8: cmd_done_o is high while flag 0 or flag 2 is set. cmd_fail_o is high while any of flags 2, 3, 4 or 5 is set.
- R9: data_done_o is high while flag 1 is set and, when dma_used_i is high, dma_done_i is also high.
- R10: data_fail_o is high while any of flags 6, 7 or 8 is set.
- R11: Register word address 0 is the flag register, 1 is the capture mask and 2 is the line mask. Reads return the 11 bits in bits 10:0 with zeros above them. Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 11 | One-cycle event pulses, bit positions as in R2 |
| dma_used_i | input | 1 | Current transfer uses DMA |
| dma_done_i | input | 1 | DMA engine has finished |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line |
| cmd_done_o | output | 1 | Command finished (complete or timeout) |
| cmd_fail_o | output | 1 | Command error seen |
| data_done_o | output | 1 | Data transfer finished |
| data_fail_o | output | 1 | Data error seen |

## Verification
Single-event pulses and multi-bit pulse patterns are applied under a full capture mask and under a partial one. This separates correct per-bit gating from masks that are ignored or shifted. Clears are tried on one bit, on all bits, and in the same cycle as an event on the cleared bit, which shows whether the event takes priority. The interrupt line is sampled in the cycle right after a flag changes and in the cycle after that, so a missing or extra register stage shows up. It is also sampled with a line mask that does not cover the raised flag. The verdict outputs are driven by each command and data flag on its own and by every combination of the DMA inputs, so a mix-up between the timeout and the error groups is caught.

// File: rtl/sdh_irq_pkg.sv
// Package: shared constants for the SD host interrupt status unit.
// Assumes an event set fixed at eleven sources; bit positions below are
// decoded by software, so their order is part of the behaviour.
package sdh_irq_pkg;

    localparam int NUM_EVT = 11;

    // Event bit positions inside the flag, capture-mask and line-mask registers
    localparam int EV_CMD_DONE   = 0;
    localparam int EV_XFER_DONE  = 1;
    localparam int EV_CMD_TOUT   = 2;
    localparam int EV_CMD_CRC    = 3;
    localparam int EV_CMD_END    = 4;
    localparam int EV_CMD_IDX    = 5;
    localparam int EV_DAT_TOUT   = 6;
    localparam int EV_DAT_CRC    = 7;
    localparam int EV_DAT_END    = 8;
    localparam int EV_BUF_RD     = 9;
    localparam int EV_BUF_WR     = 10;

    // Register word addresses
    localparam int ADR_FLAGS    = 0;
    localparam int ADR_CAPMASK  = 1;
    localparam int ADR_LINEMASK = 2;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

endpackage

// File: rtl/sdh_irq_maskreg.sv
// Module: sdh_irq_maskreg
// A plain software-written mask register, one bit per event.
// Assumes the caller has already decoded the address into wr_en_i.
module sdh_irq_maskreg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    // Hold the mask; load it on a decoded write, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en_i)
            mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/sdh_irq_flags.sv
// Module: sdh_irq_flags
// Sticky event flags with per-bit capture gating and write-one-to-clear.
// Assumes event pulses last one cycle; an accepted event beats a clear
// aimed at the same bit in the same cycle.
module sdh_irq_flags #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] capmask_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_q;
    logic [W-1:0] flags_d;
    logic [W-1:0] accept;
    logic [W-1:0] clr_mask;

    // Work out which events are captured and which bits software clears
    always_comb begin
        accept   = evt_i & capmask_i;
        clr_mask = clr_en_i ? clr_bits_i : '0;
        flags_d  = (flags_q & ~clr_mask) | accept;
    end

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    for (genvar i = 0; i < W; i++) begin : g_bit_chk
        AST_MASKED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (!capmask_i[i] && !flags_q[i]) |=> !flags_q[i]); // R3
        AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && capmask_i[i]) |=> flags_q[i]); // R5
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_bits_i[i] && !(evt_i[i] && capmask_i[i])) |=> !flags_q[i]); // R4
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !(clr_en_i && clr_bits_i[i])) |=> flags_q[i]); // R4
    end

endmodule

// File: rtl/sdh_irq_line.sv
// Module: sdh_irq_line
// Drives the interrupt line from the flags that the line mask lets through.
// Assumes a registered output is wanted: the line moves one edge after
// the flags or the mask move.
module sdh_irq_line #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] linemask_i,
    output logic         irq_o
);

    logic irq_q;

    // Register the masked reduction of the flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags_i & linemask_i);
    end

    assign irq_o = irq_q;

    AST_QUIET_WHEN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (linemask_i == '0) |=> !irq_o); // R7
    AST_NO_FLAGS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |=> !irq_o); // R6

endmodule

// File: rtl/sdh_irq_verdict.sv
// Module: sdh_irq_verdict
// Combinational command and data completion verdicts taken from the flags.
// Assumes the DMA-done input is only meaningful while DMA is in use.
module sdh_irq_verdict
    import sdh_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] flags_i,
    input  logic               dma_used_i,
    input  logic               dma_done_i,
    output logic               cmd_done_o,
    output logic               cmd_fail_o,
    output logic               data_done_o,
    output logic               data_fail_o
);

    // Judge command end, command error, data end and data error
    always_comb begin
        cmd_done_o  = flags_i[EV_CMD_DONE] | flags_i[EV_CMD_TOUT];
        cmd_fail_o  = flags_i[EV_CMD_TOUT] | flags_i[EV_CMD_CRC]
                    | flags_i[EV_CMD_END]  | flags_i[EV_CMD_IDX];
        data_done_o = flags_i[EV_XFER_DONE] & (~dma_used_i | dma_done_i);
        data_fail_o = flags_i[EV_DAT_TOUT] | flags_i[EV_DAT_CRC]
                    | flags_i[EV_DAT_END];
    end

    AST_DMA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_used_i && !dma_done_i) |-> !data_done_o); // R9
    AST_TIMEOUT_IS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i[EV_CMD_TOUT] |-> (cmd_done_o && cmd_fail_o)); // R8

endmodule

// File: rtl/sdh_irq_unit.sv
// Module: sdh_irq_unit (top)
// Interrupt status unit for an SD/MMC host: capture mask, sticky flags with
// write-one-to-clear, line mask, registered interrupt line and completion
// verdicts. Assumes single-cycle register writes and combinational reads.
module sdh_irq_unit
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              dma_used_i,
    input  logic              dma_done_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              cmd_done_o,
    output logic              cmd_fail_o,
    output logic              data_done_o,
    output logic              data_fail_o
);

    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);
    localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(ADR_CAPMASK);
    localparam logic [ADDR_W-1:0] A_LINE  = ADDR_W'(ADR_LINEMASK);

    logic         sel_flags, sel_cap, sel_line;
    evt_vec_t     wbits;
    evt_vec_t     flags, capmask, linemask;
    logic         unused_wdata;

    // Decode the register port
    always_comb begin
        sel_flags = reg_we_i && (reg_addr_i == A_FLAGS);
        sel_cap   = reg_we_i && (reg_addr_i == A_CAP);
        sel_line  = reg_we_i && (reg_addr_i == A_LINE);
        wbits     = reg_wdata_i[NUM_EVT-1:0];
    end

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_EVT];

    sdh_irq_maskreg #(.W(NUM_EVT)) u_capmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (sel_cap),
        .wdata_i (wbits),
        .mask_o  (capmask)
    );

    sdh_irq_maskreg #(.W(NUM_EVT)) u_linemask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (sel_line),
        .wdata_i (wbits),
        .mask_o  (linemask)
    );

    sdh_irq_flags #(.W(NUM_EVT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .capmask_i  (capmask),
        .clr_en_i   (sel_flags),
        .clr_bits_i (wbits),
        .flags_o    (flags)
    );

    sdh_irq_line #(.W(NUM_EVT)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flags),
        .linemask_i (linemask),
        .irq_o      (irq_o)
    );

    sdh_irq_verdict u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags_i     (flags),
        .dma_used_i  (dma_used_i),
        .dma_done_i  (dma_done_i),
        .cmd_done_o  (cmd_done_o),
        .cmd_fail_o  (cmd_fail_o),
        .data_done_o (data_done_o),
        .data_fail_o (data_fail_o)
    );

    // Read mux: mapped registers zero-extended, anything else reads zero
    always_comb begin
        unique case (reg_addr_i)
            A_FLAGS: reg_rdata_o = DATA_W'(flags);
            A_CAP:   reg_rdata_o = DATA_W'(capmask);
            A_LINE:  reg_rdata_o = DATA_W'(linemask);
            default: reg_rdata_o = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && capmask == '0 && linemask == '0 && !irq_o)); // R1

endmodule

// File: tb/sdh_irq_unit_tb.sv
// Scoreboard bench: driver tasks queue expected observations, a monitor
// process pops them, samples the outputs away from the clock edge and compares.
module sdh_irq_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          dma_used = 1'b0;
    logic          dma_done = 1'b0;
    logic          we = 1'b0;
    logic [3:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, cmd_done, cmd_fail, data_done, data_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdh_irq_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .dma_used_i  (dma_used),
        .dma_done_i  (dma_done),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .cmd_done_o  (cmd_done),
        .cmd_fail_o  (cmd_fail),
        .data_done_o (data_done),
        .data_fail_o (data_fail)
    );

    // Observation selectors: 0 read data, 1 irq, 2 cmd_done, 3 cmd_fail,
    // 4 data_done, 5 data_fail
    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    pushed = 0;
    int    popped = 0;
    int    checks = 0;
    int    errors = 0;
    bit    at_edge = 1'b0;
    bit    finished = 1'b0;

    // Monitor: compare queued expectations two time units after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = rdata;
                    1: act = {31'b0, irq};
                    2: act = {31'b0, cmd_done};
                    3: act = {31'b0, cmd_fail};
                    4: act = {31'b0, data_done};
                    default: act = {31'b0, data_fail};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
                end
                popped++;
            end
        end
    end

    task automatic chk(input int sel, input logic [3:0] a, input logic [31:0] exp,
                       input string req);
        if (!at_edge) @(negedge clk);
        at_edge = 1'b0;
        addr = a;
        q.push_back('{sel: sel, exp: exp, req: req});
        pushed++;
        wait (popped == pushed);
    endtask

    task automatic pulse(input logic [NE-1:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
        at_edge = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        at_edge = 1'b1;
    endtask

    task automatic pulse_and_clear(input logic [NE-1:0] v, input logic [31:0] d);
        @(negedge clk);
        evt = v; we = 1'b1; addr = 4'd0; wdata = d;
        @(negedge clk);
        evt = '0; we = 1'b0;
        at_edge = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expectations
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(0, 4'd0, 32'h0, "R1 flags after reset");
        chk(0, 4'd1, 32'h0, "R1 capture mask after reset");
        chk(0, 4'd2, 32'h0, "R1 line mask after reset");
        chk(1, 4'd0, 32'h0, "R1 irq after reset");

        // R2 and R7: capture everything, line mask zero
        wr(4'd1, 32'h7FF);
        pulse(11'h001);
        chk(0, 4'd0, 32'h001, "R2 single event latched");
        pulse(11'h5A0);
        chk(0, 4'd0, 32'h5A1, "R2 multi-bit pattern latched");
        chk(1, 4'd0, 32'h0, "R7 irq silent with zero line mask");
        chk(1, 4'd0, 32'h0, "R7 irq still silent");

        // R4: per-bit clear then full clear
        wr(4'd0, 32'h001);
        chk(0, 4'd0, 32'h5A0, "R4 single bit cleared");
        wr(4'd0, 32'hFFFF_FFFF);
        chk(0, 4'd0, 32'h000, "R4 all ones clears all");

        // R3: partial capture mask
        wr(4'd1, 32'h00F);
        pulse(11'h7F0);
        chk(0, 4'd0, 32'h000, "R3 masked events ignored");
        pulse(11'h7FF);
        chk(0, 4'd0, 32'h00F, "R3 only enabled bits latch");
        wr(4'd0, 32'hFFFF_FFFF);

        // R5: event and clear on the same bit in the same cycle
        wr(4'd1, 32'h7FF);
        pulse(11'h003);
        chk(0, 4'd0, 32'h003, "R5 setup");
        pulse_and_clear(11'h002, 32'h003);
        chk(0, 4'd0, 32'h002, "R5 event beats clear");
        wr(4'd0, 32'hFFFF_FFFF);

        // R6: registered line, one edge after the flag changes
        wr(4'd2, 32'h002);
        pulse(11'h001);
        chk(1, 4'd0, 32'h0, "R6 unmasked flag keeps irq low");
        chk(1, 4'd0, 32'h0, "R6 unmasked flag keeps irq low later");
        pulse(11'h002);
        chk(1, 4'd0, 32'h0, "R6 irq not yet in flag cycle");
        chk(1, 4'd0, 32'h1, "R6 irq one edge later");
        wr(4'd0, 32'h002);
        chk(1, 4'd0, 32'h1, "R6 irq still high in clear cycle");
        chk(1, 4'd0, 32'h0, "R6 irq drops one edge later");
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'h000);

        // R8: command verdicts
        pulse(11'h004);
        chk(2, 4'd0, 32'h1, "R8 timeout ends command");
        chk(3, 4'd0, 32'h1, "R8 timeout is a failure");
        wr(4'd0, 32'hFFFF_FFFF);
        pulse(11'h001);
        chk(2, 4'd0, 32'h1, "R8 complete ends command");
        chk(3, 4'd0, 32'h0, "R8 complete is no failure");
        wr(4'd0, 32'hFFFF_FFFF);
        pulse(11'h020);
        chk(2, 4'd0, 32'h0, "R8 index error alone is not done");
        chk(3, 4'd0, 32'h1, "R8 index error is a failure");
        wr(4'd0, 32'hFFFF_FFFF);

        // R9: data done with and without DMA
        pulse(11'h002);
        dma_used = 1'b1; dma_done = 1'b0;
        chk(4, 4'd0, 32'h0, "R9 waits for DMA done");
        dma_done = 1'b1;
        chk(4, 4'd0, 32'h1, "R9 done with DMA done");
        dma_used = 1'b0; dma_done = 1'b0;
        chk(4, 4'd0, 32'h1, "R9 done without DMA");
        wr(4'd0, 32'hFFFF_FFFF);
        chk(4, 4'd0, 32'h0, "R9 not done after clear");

        // R10: data failures
        pulse(11'h080);
        chk(5, 4'd0, 32'h1, "R10 data CRC error");
        wr(4'd0, 32'hFFFF_FFFF);
        chk(5, 4'd0, 32'h0, "R10 cleared");
        pulse(11'h040);
        chk(5, 4'd0, 32'h1, "R10 data timeout");
        wr(4'd0, 32'hFFFF_FFFF);
        pulse(11'h100);
        chk(5, 4'd0, 32'h1, "R10 data end-bit error");
        chk(2, 4'd0, 32'h0, "R10 data error does not end command");
        wr(4'd0, 32'hFFFF_FFFF);

        // R11: register map
        wr(4'd3, 32'hFFFF_FFFF);
        chk(0, 4'd3, 32'h0, "R11 unmapped address reads zero");
        chk(0, 4'd1, 32'h7FF, "R11 unmapped write leaves capture mask");
        chk(0, 4'd2, 32'h000, "R11 unmapped write leaves line mask");
        wr(4'd2, 32'hFFFF_FFFF);
        chk(0, 4'd2, 32'h7FF, "R11 upper bits read zero");

        // R1: reset in mid-run
        pulse(11'h7FF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        at_edge = 1'b1;
        chk(0, 4'd0, 32'h0, "R1 flags after mid-run reset");
        chk(0, 4'd1, 32'h0, "R1 capture mask after mid-run reset");
        chk(1, 4'd0, 32'h0, "R1 irq after mid-run reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule